// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block is the multi-cycle controller in a small processor core that decides when a device interrupt is accepted. It then walks the core through the entry and the return of the handler. It holds the program counter, the status word and the live stack pointer. It also keeps two parked stack pointers, one for the user stack and one for the privileged stack. All its stack and vector traffic goes through one memory port that uses a request/ready handshake.

An interrupt is accepted only at an instruction boundary. On entry the old status word is captured before anything changes. The status word then moves to privileged mode, takes on the device's priority and has its condition codes cleared. When the interrupted program ran in user mode, the stack pointers are exchanged. The old PC and the old status word are pushed onto the privileged stack. The handler address is then read from a vector table. A return strobe reverses the sequence. The status word is popped first and the PC second, and if the restored status word says user mode, the user stack pointer comes back.

While idle, the rest of the core can write the PC, the status word and the stack pointer through a load port.

Top module: `irq_seq`

## Requirements
- R1: A sequence starts at an edge only when the block is idle, `insn_done`, `dev_req` and `dev_ie` are all high, and `dev_prio` is strictly greater than the priority field of the status word (bits 10:8). In every other case the block stays idle and PC, status word and stack pointer are unchanged.
- R2: After entry the status word has bit 15 (privileged mode, 1 = privileged) set, bits 10:8 equal to the device priority and bits 2:0 (condition codes) cleared. All other bits are kept.
- R3: Entry from user mode (bit 15 = 0) parks the current stack pointer and switches to the parked privileged stack pointer. Entry from privileged mode keeps the current stack pointer.
- R4: Entry pushes the old PC and then the old status word. Each push first decrements the stack pointer and then writes there, so the PC lands at SP-1, the status word at SP-2, and SP ends at SP-2.
- R5: After the pushes, the PC is loaded with the word read from address 0x0100 + vector number.
- R6: On `rti_go` the status word is popped from SP and then the PC from SP+1, and SP advances by 2. If the restored bit 15 is 0, the privileged stack pointer is parked and the user stack pointer is restored.
- R7: A memory request keeps its address, direction and write data stable until `mem_rdy`. Each access completes in the cycle in which `mem_req` and `mem_rdy` are both high.
- R8: If `rti_go` and an acceptable interrupt occur in the same cycle, the return sequence runs.
- R9: `ld_en` writes `ld_pc`, `ld_psr` and `ld_sp` only while idle and when no sequence is starting. While the block is busy it is ignored.
- R10: Reset gives PC 0x0000, status word 0x0000 (user mode, priority 0), stack pointer 0x0200, parked privileged stack pointer 0x0300, idle and no memory request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dev_req | input | 1 | Device service request (ready/done) |
| dev_ie | input | 1 | Device interrupt enable |
| dev_prio | input | 3 | Device priority level |
| dev_vec | input | 8 | Device vector number |
| insn_done | input | 1 | Current instruction has completed (boundary strobe) |
| rti_go | input | 1 | Start return-from-interrupt |
| ld_en | input | 1 | Core writes PC, status word and stack pointer |
| ld_pc | input | 16 | PC value to load |
| ld_psr | input | 16 | Status word value to load |
| ld_sp | input | 16 | Stack pointer value to load |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 16 | Word address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid with mem_rdy |
| mem_rdy | input | 1 | Memory completes the access |
| pc_o | output | 16 | Program counter |
| psr_o | output | 16 | Status word |
| sp_o | output | 16 | Live stack pointer |
| busy_o | output | 1 | A sequence is in progress |

## Verification
The hardest case to reach from the ports is the parked-pointer bookkeeping across mixed modes. The user stack pointer must come back after a round trip, and the parked privileged pointer must have been re-parked correctly, or the next user-mode entry pushes to the wrong place. The stimulus table therefore interleaves user-mode and privileged-mode entries, each followed by a return, and checks the push addresses of every later entry against the fixed privileged stack top. A directed test asserts the return strobe and a winning interrupt in the same cycle. Another sends load-port writes while memory is stalled.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

   typedef enum logic [2:0] {
      S_IDLE     = 3'd0,
      S_PUSH_PC  = 3'd1,
      S_PUSH_PSR = 3'd2,
      S_VEC_RD   = 3'd3,
      S_POP_PSR  = 3'd4,
      S_POP_PC   = 3'd5
   } seq_state_e;

endpackage

// File: rtl/irq_take_check.sv
module irq_take_check #(
   parameter int PRIO_W = 3
) (
   input  logic              idle,
   input  logic              insn_done,
   input  logic              dev_req,
   input  logic              dev_ie,
   input  logic [PRIO_W-1:0] dev_prio,
   input  logic [PRIO_W-1:0] cur_prio,
   output logic              take
);

   logic outranks;

   generate
      if (PRIO_W == 1) begin : g_one_bit
         assign outranks = dev_prio[0] & ~cur_prio[0];
      end else begin : g_multi_bit
         assign outranks = (dev_prio > cur_prio);
      end
   endgenerate

   assign take = idle & insn_done & dev_req & dev_ie & outranks;

endmodule

// File: rtl/irq_seq_ctl.sv
module irq_seq_ctl
   import irq_seq_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       rti_go,
   input  logic       take,
   input  logic       hs,
   output seq_state_e st
);

   seq_state_e st_nx;

   always_comb begin
      st_nx = st;
      unique case (st)
         S_IDLE: begin
            if (rti_go)    st_nx = S_POP_PSR;
            else if (take) st_nx = S_PUSH_PC;
         end
         S_PUSH_PC:  if (hs) st_nx = S_PUSH_PSR;
         S_PUSH_PSR: if (hs) st_nx = S_VEC_RD;
         S_VEC_RD:   if (hs) st_nx = S_IDLE;
         S_POP_PSR:  if (hs) st_nx = S_POP_PC;
         S_POP_PC:   if (hs) st_nx = S_IDLE;
         default:    st_nx = S_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) st <= S_IDLE;
      else        st <= st_nx;
   end

endmodule

// File: rtl/irq_mem_port.sv
module irq_mem_port
   import irq_seq_pkg::*;
#(
   parameter int                ADDR_W    = 16,
   parameter int                DATA_W    = 16,
   parameter int                VEC_W     = 8,
   parameter int                VEC_SHIFT = 0,
   parameter logic [ADDR_W-1:0] VEC_BASE  = 16'h0100
) (
   input  seq_state_e        st,
   input  logic [ADDR_W-1:0] sp,
   input  logic [VEC_W-1:0]  vec_q,
   input  logic [ADDR_W-1:0] old_pc,
   input  logic [DATA_W-1:0] old_psr,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata
);

   logic [ADDR_W-1:0] vec_off;
   logic [ADDR_W-1:0] sp_dec;

   generate
      if (VEC_SHIFT == 0) begin : g_word_entry
         assign vec_off = ADDR_W'(vec_q);
      end else begin : g_wide_entry
         assign vec_off = ADDR_W'(vec_q) << VEC_SHIFT;
      end
   endgenerate

   assign sp_dec = sp - ADDR_W'(1);

   always_comb begin
      mem_req   = 1'b0;
      mem_we    = 1'b0;
      mem_addr  = '0;
      mem_wdata = '0;
      unique case (st)
         S_PUSH_PC: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = sp_dec;
            mem_wdata = DATA_W'(old_pc);
         end
         S_PUSH_PSR: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = sp_dec;
            mem_wdata = old_psr;
         end
         S_VEC_RD: begin
            mem_req  = 1'b1;
            mem_addr = VEC_BASE + vec_off;
         end
         S_POP_PSR, S_POP_PC: begin
            mem_req  = 1'b1;
            mem_addr = sp;
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/irq_seq.sv
module irq_seq
   import irq_seq_pkg::*;
#(
   parameter int                ADDR_W    = 16,
   parameter int                DATA_W    = 16,
   parameter int                PRIO_W    = 3,
   parameter int                VEC_W     = 8,
   parameter int                CC_W      = 3,
   parameter int                PRIO_LSB  = 8,
   parameter int                MODE_BIT  = 15,
   parameter int                VEC_SHIFT = 0,
   parameter logic [ADDR_W-1:0] VEC_BASE  = 16'h0100,
   parameter logic [ADDR_W-1:0] RST_PC    = 16'h0000,
   parameter logic [DATA_W-1:0] RST_PSR   = 16'h0000,
   parameter logic [ADDR_W-1:0] RST_SP    = 16'h0200,
   parameter logic [ADDR_W-1:0] RST_SSP   = 16'h0300
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dev_req,
   input  logic              dev_ie,
   input  logic [PRIO_W-1:0] dev_prio,
   input  logic [VEC_W-1:0]  dev_vec,
   input  logic              insn_done,
   input  logic              rti_go,
   input  logic              ld_en,
   input  logic [ADDR_W-1:0] ld_pc,
   input  logic [DATA_W-1:0] ld_psr,
   input  logic [ADDR_W-1:0] ld_sp,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic              mem_rdy,
   output logic [ADDR_W-1:0] pc_o,
   output logic [DATA_W-1:0] psr_o,
   output logic [ADDR_W-1:0] sp_o,
   output logic              busy_o
);

   localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

   generate
      if (ADDR_W != DATA_W) begin : g_chk_width
         $error("irq_seq: PC is pushed as a data word, ADDR_W must equal DATA_W");
      end
      if (MODE_BIT >= DATA_W) begin : g_chk_mode
         $error("irq_seq: MODE_BIT outside the status word");
      end
      if (PRIO_LSB + PRIO_W > MODE_BIT) begin : g_chk_prio
         $error("irq_seq: priority field overlaps the mode bit");
      end
      if (CC_W > PRIO_LSB || CC_W < 1) begin : g_chk_cc
         $error("irq_seq: condition-code field must sit below the priority field");
      end
      if (VEC_W + VEC_SHIFT > ADDR_W) begin : g_chk_vec
         $error("irq_seq: vector offset does not fit the address");
      end
   endgenerate

   seq_state_e        st;
   logic              take;
   logic              hs;
   logic              idle;

   logic [ADDR_W-1:0] pc;
   logic [DATA_W-1:0] psr;
   logic [ADDR_W-1:0] sp;
   logic [ADDR_W-1:0] usp_park;
   logic [ADDR_W-1:0] ssp_park;
   logic [ADDR_W-1:0] old_pc;
   logic [DATA_W-1:0] old_psr;
   logic [VEC_W-1:0]  vec_q;
   logic [DATA_W-1:0] entry_psr;
   logic              in_user;

   assign idle    = (st == S_IDLE);
   assign hs      = mem_req & mem_rdy;
   assign in_user = ~psr[MODE_BIT];

   irq_take_check #(
      .PRIO_W (PRIO_W)
   ) u_take (
      .idle      (idle),
      .insn_done (insn_done),
      .dev_req   (dev_req),
      .dev_ie    (dev_ie),
      .dev_prio  (dev_prio),
      .cur_prio  (psr[PRIO_LSB +: PRIO_W]),
      .take      (take)
   );

   irq_seq_ctl u_ctl (
      .clk    (clk),
      .rst_n  (rst_n),
      .rti_go (rti_go),
      .take   (take),
      .hs     (hs),
      .st     (st)
   );

   irq_mem_port #(
      .ADDR_W    (ADDR_W),
      .DATA_W    (DATA_W),
      .VEC_W     (VEC_W),
      .VEC_SHIFT (VEC_SHIFT),
      .VEC_BASE  (VEC_BASE)
   ) u_port (
      .st        (st),
      .sp        (sp),
      .vec_q     (vec_q),
      .old_pc    (old_pc),
      .old_psr   (old_psr),
      .mem_req   (mem_req),
      .mem_we    (mem_we),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata)
   );

   always_comb begin
      entry_psr                     = psr;
      entry_psr[MODE_BIT]           = 1'b1;
      entry_psr[PRIO_LSB +: PRIO_W] = dev_prio;
      entry_psr[CC_W-1:0]           = '0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pc       <= RST_PC;
         psr      <= RST_PSR;
         sp       <= RST_SP;
         usp_park <= RST_SP;
         ssp_park <= RST_SSP;
         old_pc   <= '0;
         old_psr  <= '0;
         vec_q    <= '0;
      end else begin
         unique case (st)
            S_IDLE: begin
               if (rti_go) begin
                  // return sequence starts; nothing captured here
               end else if (take) begin
                  old_pc  <= pc;
                  old_psr <= psr;
                  vec_q   <= dev_vec;
                  psr     <= entry_psr;
                  if (in_user) begin
                     usp_park <= sp;
                     sp       <= ssp_park;
                  end
               end else if (ld_en) begin
                  pc  <= ld_pc;
                  psr <= ld_psr;
                  sp  <= ld_sp;
               end
            end
            S_PUSH_PC, S_PUSH_PSR: begin
               if (hs) sp <= sp - ONE;
            end
            S_VEC_RD: begin
               if (hs) pc <= ADDR_W'(mem_rdata);
            end
            S_POP_PSR: begin
               if (hs) begin
                  psr <= mem_rdata;
                  sp  <= sp + ONE;
               end
            end
            S_POP_PC: begin
               if (hs) begin
                  pc <= ADDR_W'(mem_rdata);
                  if (in_user) begin
                     ssp_park <= sp + ONE;
                     sp       <= usp_park;
                  end else begin
                     sp <= sp + ONE;
                  end
               end
            end
            default: ;
         endcase
      end
   end

   assign pc_o   = pc;
   assign psr_o  = psr;
   assign sp_o   = sp;
   assign busy_o = ~idle;

endmodule

// File: rtl/irq_seq_chk.sv
module irq_seq_chk
   import irq_seq_pkg::*;
#(
   parameter int ADDR_W   = 16,
   parameter int DATA_W   = 16,
   parameter int PRIO_W   = 3,
   parameter int CC_W     = 3,
   parameter int PRIO_LSB = 8,
   parameter int MODE_BIT = 15
) (
   input logic              clk,
   input logic              rst_n,
   input seq_state_e        st,
   input logic              take,
   input logic              dev_req,
   input logic              dev_ie,
   input logic [PRIO_W-1:0] dev_prio,
   input logic              insn_done,
   input logic              rti_go,
   input logic              mem_req,
   input logic              mem_we,
   input logic              mem_rdy,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [DATA_W-1:0] mem_wdata,
   input logic [ADDR_W-1:0] pc,
   input logic [DATA_W-1:0] psr,
   input logic [ADDR_W-1:0] sp
);

   // R1
   no_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_IDLE && !rti_go &&
       !(insn_done && dev_req && dev_ie && dev_prio > psr[PRIO_LSB +: PRIO_W]))
      |=> (st == S_IDLE));

   // R2
   entry_psr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_IDLE && !rti_go && take)
      |=> (psr[MODE_BIT] && psr[PRIO_LSB +: PRIO_W] == $past(dev_prio) &&
           psr[CC_W-1:0] == '0));

   // R3
   priv_keep_sp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_IDLE && !rti_go && take && psr[MODE_BIT])
      |=> (sp == $past(sp)));

   // R4
   push_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we && mem_rdy) |=> (sp == $past(sp) - ADDR_W'(1)));

   // R7
   hold_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_rdy)
      |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

   // R8
   rti_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_IDLE && rti_go) |=> (st == S_POP_PSR));

   // R9
   stall_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st != S_IDLE && !(mem_req && mem_rdy))
      |=> ($stable(pc) && $stable(psr) && $stable(sp)));

endmodule

bind irq_seq irq_seq_chk #(
   .ADDR_W   (ADDR_W),
   .DATA_W   (DATA_W),
   .PRIO_W   (PRIO_W),
   .CC_W     (CC_W),
   .PRIO_LSB (PRIO_LSB),
   .MODE_BIT (MODE_BIT)
) u_irq_seq_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .st        (st),
   .take      (take),
   .dev_req   (dev_req),
   .dev_ie    (dev_ie),
   .dev_prio  (dev_prio),
   .insn_done (insn_done),
   .rti_go    (rti_go),
   .mem_req   (mem_req),
   .mem_we    (mem_we),
   .mem_rdy   (mem_rdy),
   .mem_addr  (mem_addr),
   .mem_wdata (mem_wdata),
   .pc        (pc),
   .psr       (psr),
   .sp        (sp)
);

// File: tb/test_irq_seq.sv
module test_irq_seq;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        dev_req = 1'b0, dev_ie = 1'b0, insn_done = 1'b0, rti_go = 1'b0, ld_en = 1'b0;
   logic [2:0]  dev_prio = '0;
   logic [7:0]  dev_vec = '0;
   logic [15:0] ld_pc = '0, ld_psr = '0, ld_sp = '0;
   logic        mem_req, mem_we, mem_rdy, busy_o;
   logic [15:0] mem_addr, mem_wdata, mem_rdata, pc_o, psr_o, sp_o;

   int n_chk = 0;
   int n_bad = 0;
   int lat = 0;
   int wcnt = 0;
   bit [15:0] mem [0:1023];

   always #5 clk = ~clk;

   irq_seq i_irq_seq (
      .clk(clk), .rst_n(rst_n), .dev_req(dev_req), .dev_ie(dev_ie),
      .dev_prio(dev_prio), .dev_vec(dev_vec), .insn_done(insn_done),
      .rti_go(rti_go), .ld_en(ld_en), .ld_pc(ld_pc), .ld_psr(ld_psr),
      .ld_sp(ld_sp), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_rdy(mem_rdy),
      .pc_o(pc_o), .psr_o(psr_o), .sp_o(sp_o), .busy_o(busy_o)
   );

   // memory model: ready after lat waiting cycles, vector table at 0x0100
   assign mem_rdy   = mem_req && (wcnt >= lat);
   assign mem_rdata = mem[mem_addr[9:0]];

   always @(posedge clk) begin
      if (!rst_n) begin
         wcnt <= 0;
         for (int v = 0; v < 256; v++) mem[256 + v] <= 16'h4000 + 16'(v * 3);
      end else if (mem_req && mem_rdy) begin
         wcnt <= 0;
         if (mem_we) mem[mem_addr[9:0]] <= mem_wdata;
      end else if (mem_req) begin
         wcnt <= wcnt + 1;
      end
   end

   typedef struct packed {
      logic       usr;
      logic [2:0] cprio;
      logic       req;
      logic       ie;
      logic       done;
      logic [2:0] dprio;
      logic [7:0] vec;
      logic       exp;
   } vec_t;

   localparam vec_t TBL [8] = '{
      '{1'b1, 3'd0, 1'b1, 1'b1, 1'b1, 3'd3, 8'd5,   1'b1},
      '{1'b1, 3'd3, 1'b1, 1'b1, 1'b1, 3'd3, 8'd6,   1'b0},
      '{1'b1, 3'd2, 1'b1, 1'b0, 1'b1, 3'd3, 8'd7,   1'b0},
      '{1'b1, 3'd0, 1'b0, 1'b1, 1'b1, 3'd4, 8'd8,   1'b0},
      '{1'b1, 3'd0, 1'b1, 1'b1, 1'b0, 3'd4, 8'd9,   1'b0},
      '{1'b0, 3'd2, 1'b1, 1'b1, 1'b1, 3'd5, 8'd9,   1'b1},
      '{1'b1, 3'd6, 1'b1, 1'b1, 1'b1, 3'd7, 8'd255, 1'b1},
      '{1'b0, 3'd7, 1'b1, 1'b1, 1'b1, 3'd7, 8'd2,   1'b0}
   };

   function automatic logic [15:0] mk_psr(logic priv, logic [2:0] prio, logic [2:0] cc);
      return {priv, 4'b0000, prio, 5'b00000, cc};
   endfunction

   task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic wait_idle();
      int t = 0;
      while (busy_o === 1'b1 && t < 500) begin
         @(negedge clk);
         t++;
      end
      if (busy_o !== 1'b0) begin
         n_chk++;
         n_bad++;
         $display("FAIL R7 sequence hung act=%b exp=0", busy_o);
      end
   endtask

   task automatic load(logic [15:0] pc, logic [15:0] psr, logic [15:0] sp);
      @(negedge clk);
      ld_en = 1'b1; ld_pc = pc; ld_psr = psr; ld_sp = sp;
      @(negedge clk);
      ld_en = 1'b0;
   endtask

   task automatic do_rti();
      @(negedge clk);
      rti_go = 1'b1;
      @(negedge clk);
      rti_go = 1'b0;
      wait_idle();
   endtask

   task automatic raise(logic req, logic ie, logic done, logic [2:0] prio, logic [7:0] vec);
      @(negedge clk);
      dev_req = req; dev_ie = ie; insn_done = done; dev_prio = prio; dev_vec = vec;
      @(negedge clk);
      dev_req = 1'b0; insn_done = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10 reset state
      chk("R10 pc", pc_o, 16'h0000);
      chk("R10 psr", psr_o, 16'h0000);
      chk("R10 sp", sp_o, 16'h0200);
      chk("R10 busy", {15'b0, busy_o}, 16'h0000);
      chk("R10 mem_req", {15'b0, mem_req}, 16'h0000);

      // table walk
      for (int i = 0; i < 8; i++) begin
         logic [15:0] opc, opsr, osp, base;
         lat  = i % 3;
         opc  = 16'h1000 + 16'(i);
         opsr = mk_psr(~TBL[i].usr, TBL[i].cprio, 3'b101);
         osp  = TBL[i].usr ? 16'h0200 : 16'h0280;
         base = TBL[i].usr ? 16'h0300 : 16'h0280;
         load(opc, opsr, osp);
         chk("R9 load pc", pc_o, opc);
         chk("R9 load psr", psr_o, opsr);
         raise(TBL[i].req, TBL[i].ie, TBL[i].done, TBL[i].dprio, TBL[i].vec);
         chk("R1 taken", {15'b0, busy_o}, {15'b0, TBL[i].exp});
         if (TBL[i].exp) begin
            wait_idle();
            chk("R5 handler pc", pc_o, 16'h4000 + 16'(32'(TBL[i].vec) * 3));
            chk("R2 entry psr", psr_o, mk_psr(1'b1, TBL[i].dprio, 3'b000));
            chk("R3 R4 entry sp", sp_o, base - 16'd2);
            chk("R4 pushed pc", mem[10'(base - 16'd1)], opc);
            chk("R4 pushed psr", mem[10'(base - 16'd2)], opsr);
            do_rti();
            chk("R6 pc back", pc_o, opc);
            chk("R6 psr back", psr_o, opsr);
            chk("R6 sp back", sp_o, osp);
         end else begin
            chk("R1 pc kept", pc_o, opc);
            chk("R1 psr kept", psr_o, opsr);
            chk("R1 sp kept", sp_o, osp);
         end
      end

      // R7 stall timing and R9 load ignored while busy
      begin
         int cyc = 0;
         lat = 3;
         load(16'h3333, mk_psr(1'b0, 3'd1, 3'b011), 16'h0200);
         @(negedge clk);
         dev_req = 1'b1; dev_ie = 1'b1; insn_done = 1'b1; dev_prio = 3'd2; dev_vec = 8'd4;
         @(negedge clk);
         dev_req = 1'b0; insn_done = 1'b0;
         ld_en = 1'b1; ld_pc = 16'hDEAD; ld_psr = 16'h00FF; ld_sp = 16'h0111;
         while (busy_o === 1'b1 && cyc < 100) begin
            cyc++;
            @(negedge clk);
            ld_en = 1'b0;
         end
         chk("R7 stalled cycles", 16'(cyc), 16'd12);
         chk("R9 busy load ignored pc", pc_o, 16'h4000 + 16'd12);
         chk("R9 busy load ignored sp", sp_o, 16'h02FE);
         do_rti();
         chk("R6 after stalls pc", pc_o, 16'h3333);
         chk("R6 after stalls sp", sp_o, 16'h0200);
      end

      // R8 return wins over a simultaneous interrupt
      lat = 1;
      load(16'h2222, mk_psr(1'b0, 3'd0, 3'b001), 16'h0200);
      raise(1'b1, 1'b1, 1'b1, 3'd4, 8'd1);
      wait_idle();
      @(negedge clk);
      rti_go = 1'b1; insn_done = 1'b1; dev_req = 1'b1; dev_ie = 1'b1; dev_prio = 3'd7;
      @(negedge clk);
      rti_go = 1'b0; insn_done = 1'b0; dev_req = 1'b0;
      wait_idle();
      chk("R8 pc", pc_o, 16'h2222);
      chk("R8 psr", psr_o, mk_psr(1'b0, 3'd0, 3'b001));
      chk("R8 sp", sp_o, 16'h0200);

      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule